// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit works out where a 32-bit RISC core fetches next. Each cycle it takes the current program counter, a decoded control-transfer kind, two register operands, the 16-bit branch displacement, the 26-bit absolute jump field and a register value for indirect jumps. From these it produces the next program counter, a flag saying whether control flow left the sequential path, and a link request made of a write enable and the return address to store in register 31.

Conditional branches compare their operands inside the branch itself. Either two registers are tested for equality or inequality, or one register is compared with zero as a signed value. A taken branch lands at PC+4 plus the displacement scaled to words. Absolute jumps keep the top four bits of PC+4 and fill the rest from the scaled 26-bit field. Indirect jumps take the register value unchanged. The link forms (branch-and-link on sign, jump-and-link) also ask for PC+4 to be written to register 31.

All outputs are registered. They show the result for the inputs sampled at the previous rising clock edge. Delay slots, flushing and fetch are handled outside this unit.

Top module: `bnpc_unit`

## Requirements
- R1: While rst_n is low at a rising edge, next_pc and link_val become 0, and taken and link_we become 0, from the edge that follows.
- R2: Kind code 0 (sequential), and every code from 12 to 15, gives next_pc = cur_pc+4, taken = 0 and link_we = 0.
- R3: Code 1 (branch if opnd_a == opnd_b) and code 2 (branch if opnd_a != opnd_b) are taken exactly when their condition holds.
- R4: Codes 3, 4, 5 and 6 branch when opnd_a, read as signed two's complement, is <= 0, > 0, < 0 and >= 0 respectively.
- R5: A taken conditional branch gives next_pc = cur_pc + 4 + (sign-extended br_off << 2). A branch that is not taken gives cur_pc + 4.
- R6: Code 7 (branch-and-link if opnd_a < 0) and code 8 (branch-and-link if opnd_a >= 0) follow the R5 target rule, and they assert link_we with link_val = cur_pc+4 whether or not they are taken.
- R7: Code 9 (absolute jump) is always taken, with next_pc = {bits 31:28 of cur_pc+4, jmp_field, 2'b00}, and link_we = 0.
- R8: Code 10 (jump-and-link) gives the R7 target and taken = 1, plus link_we = 1 and link_val = cur_pc+4.
- R9: Code 11 (register jump) gives next_pc = jreg_val, taken = 1 and link_we = 0.
- R10: The outputs change only at a rising clock edge, and they reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_pc | input | 32 | Program counter of the current instruction |
| br_kind | input | 4 | Decoded control-transfer kind (codes in R2 to R9) |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| br_off | input | 16 | Branch displacement in words, signed |
| jmp_field | input | 26 | Absolute jump word index |
| jreg_val | input | 32 | Target register value for register jumps |
| next_pc | output | 32 | Registered next program counter |
| taken | output | 1 | Registered flag: flow left the sequential path |
| link_we | output | 1 | Registered request to write register 31 |
| link_val | output | 32 | Registered return address (cur_pc+4) |

## Verification
The unit holds no state apart from its output registers. A wrong decode or a wrong condition shows up at the ports one clock after the offending input, as a bad taken flag or a bad next_pc. The sweep covers every kind code against signed boundary operands, including zero, -1, the most negative value and the most positive value. It also drives displacements at both signed extremes and PCs near the 256 MB region edge, so that sign-extension errors and upper-bit selection errors appear in the very next cycle.

// File: rtl/bnpc_pkg.sv
// Shared codes and control types for the branch / next-PC unit.
// Assumes a 4-bit kind code driven by the instruction decoder.
package bnpc_pkg;

    localparam int KIND_W = 4;

    localparam logic [KIND_W-1:0] K_SEQ    = 4'd0;
    localparam logic [KIND_W-1:0] K_BEQ    = 4'd1;
    localparam logic [KIND_W-1:0] K_BNE    = 4'd2;
    localparam logic [KIND_W-1:0] K_BLEZ   = 4'd3;
    localparam logic [KIND_W-1:0] K_BGTZ   = 4'd4;
    localparam logic [KIND_W-1:0] K_BLTZ   = 4'd5;
    localparam logic [KIND_W-1:0] K_BGEZ   = 4'd6;
    localparam logic [KIND_W-1:0] K_BLTZL  = 4'd7;
    localparam logic [KIND_W-1:0] K_BGEZL  = 4'd8;
    localparam logic [KIND_W-1:0] K_JABS   = 4'd9;
    localparam logic [KIND_W-1:0] K_JABSL  = 4'd10;
    localparam logic [KIND_W-1:0] K_JREG   = 4'd11;

    // Condition selected for a conditional branch
    typedef enum logic [2:0] {
        C_NEVER = 3'd0,
        C_EQ    = 3'd1,
        C_NE    = 3'd2,
        C_LEZ   = 3'd3,
        C_GTZ   = 3'd4,
        C_LTZ   = 3'd5,
        C_GEZ   = 3'd6
    } cond_e;

    // Decoded control for one instruction
    typedef struct packed {
        logic  cond_br;   // conditional, PC-relative
        logic  jabs;      // absolute region jump
        logic  jreg;      // register-indirect jump
        logic  link;      // request register 31 write
        cond_e cond;
    } ctrl_t;

endpackage

// File: rtl/bnpc_decode.sv
// Maps the kind code onto control fields.
// Assumes: codes not listed decode to the sequential path.
module bnpc_decode
    import bnpc_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    output ctrl_t             ctrl
);

    // Purpose: translate kind code into control fields
    always_comb begin
        ctrl = '{cond_br: 1'b0, jabs: 1'b0, jreg: 1'b0, link: 1'b0, cond: C_NEVER};
        case (kind)
            K_BEQ:   begin ctrl.cond_br = 1'b1; ctrl.cond = C_EQ;  end
            K_BNE:   begin ctrl.cond_br = 1'b1; ctrl.cond = C_NE;  end
            K_BLEZ:  begin ctrl.cond_br = 1'b1; ctrl.cond = C_LEZ; end
            K_BGTZ:  begin ctrl.cond_br = 1'b1; ctrl.cond = C_GTZ; end
            K_BLTZ:  begin ctrl.cond_br = 1'b1; ctrl.cond = C_LTZ; end
            K_BGEZ:  begin ctrl.cond_br = 1'b1; ctrl.cond = C_GEZ; end
            K_BLTZL: begin ctrl.cond_br = 1'b1; ctrl.cond = C_LTZ; ctrl.link = 1'b1; end
            K_BGEZL: begin ctrl.cond_br = 1'b1; ctrl.cond = C_GEZ; ctrl.link = 1'b1; end
            K_JABS:  begin ctrl.jabs = 1'b1; end
            K_JABSL: begin ctrl.jabs = 1'b1; ctrl.link = 1'b1; end
            K_JREG:  begin ctrl.jreg = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/bnpc_cond.sv
// Evaluates the fused branch comparison.
// Assumes operands are two's complement for the zero comparisons.
module bnpc_cond
    import bnpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_e           cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit
);

    logic same;
    logic neg;
    logic zero;

    // Purpose: primitive comparison flags
    always_comb begin
        same = (a == b);
        neg  = a[XLEN-1];
        zero = ~|a;
    end

    // Purpose: select the flag combination for the condition
    always_comb begin
        case (cond)
            C_EQ:    hit = same;
            C_NE:    hit = ~same;
            C_LEZ:   hit = neg | zero;
            C_GTZ:   hit = ~neg & ~zero;
            C_LTZ:   hit = neg;
            C_GEZ:   hit = ~neg;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bnpc_target.sv
// Computes the sequential, PC-relative and absolute-region targets.
// Assumes XLEN > OFF_W and XLEN > TGT_W + word shift.
module bnpc_target #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int TGT_W = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic [TGT_W-1:0] field,
    output logic [XLEN-1:0]  pc_seq,
    output logic [XLEN-1:0]  pc_rel,
    output logic [XLEN-1:0]  pc_abs
);

    localparam int WSH  = 2;
    localparam int HI_W = XLEN - TGT_W - WSH;
    localparam logic [XLEN-1:0] STEP = XLEN'(1 << WSH);

    logic [XLEN-1:0] off_ext;

    // Purpose: sequential successor
    always_comb pc_seq = pc + STEP;

    // Purpose: sign-extend and word-scale the displacement
    always_comb off_ext = {{(XLEN-OFF_W-WSH){off[OFF_W-1]}}, off, {WSH{1'b0}}};

    // Purpose: PC-relative target from the successor
    always_comb pc_rel = pc_seq + off_ext;

    // Purpose: region jump keeps the successor's top bits
    always_comb pc_abs = {pc_seq[XLEN-1 -: HI_W], field, {WSH{1'b0}}};

endmodule

// File: rtl/bnpc_unit.sv
// Top of the branch / next-PC unit: decode, compare, target selection
// and the registered outputs. Assumes synchronous active-low reset.
module bnpc_unit
    import bnpc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int TGT_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [KIND_W-1:0] br_kind,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [TGT_W-1:0]  jmp_field,
    input  logic [XLEN-1:0]   jreg_val,
    output logic [XLEN-1:0]   next_pc,
    output logic              taken,
    output logic              link_we,
    output logic [XLEN-1:0]   link_val
);

    ctrl_t           ctrl;
    logic            hit;
    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] pc_rel;
    logic [XLEN-1:0] pc_abs;
    logic [XLEN-1:0] nxt_d;
    logic            tkn_d;

    bnpc_decode u_dec (
        .kind (br_kind),
        .ctrl (ctrl)
    );

    bnpc_cond #(.XLEN(XLEN)) u_cmp (
        .cond (ctrl.cond),
        .a    (opnd_a),
        .b    (opnd_b),
        .hit  (hit)
    );

    bnpc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_tgt (
        .pc     (cur_pc),
        .off    (br_off),
        .field  (jmp_field),
        .pc_seq (pc_seq),
        .pc_rel (pc_rel),
        .pc_abs (pc_abs)
    );

    // Purpose: pick the next PC and the taken flag
    always_comb begin
        tkn_d = ctrl.jreg | ctrl.jabs | (ctrl.cond_br & hit);
        if (ctrl.jreg)                nxt_d = jreg_val;
        else if (ctrl.jabs)           nxt_d = pc_abs;
        else if (ctrl.cond_br && hit) nxt_d = pc_rel;
        else                          nxt_d = pc_seq;
    end

    // Purpose: register all outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc  <= '0;
            taken    <= 1'b0;
            link_we  <= 1'b0;
            link_val <= '0;
        end else begin
            next_pc  <= nxt_d;
            taken    <= tkn_d;
            link_we  <= ctrl.link;
            link_val <= pc_seq;
        end
    end

endmodule

// File: rtl/bnpc_unit_chk.sv
// Temporal checks on bnpc_unit ports, bound into every instance.
module bnpc_unit_chk
    import bnpc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int TGT_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   cur_pc,
    input logic [KIND_W-1:0] br_kind,
    input logic [XLEN-1:0]   opnd_a,
    input logic [XLEN-1:0]   opnd_b,
    input logic [OFF_W-1:0]  br_off,
    input logic [TGT_W-1:0]  jmp_field,
    input logic [XLEN-1:0]   jreg_val,
    input logic [XLEN-1:0]   next_pc,
    input logic              taken,
    input logic              link_we,
    input logic [XLEN-1:0]   link_val
);

    localparam logic [XLEN-1:0] FOUR = XLEN'(4);

    // R2
    seq_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_kind) == K_SEQ) |->
        (next_pc == $past(cur_pc) + FOUR && !taken && !link_we));

    // R5
    not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken) |-> (next_pc == $past(cur_pc) + FOUR));

    // R3
    beq_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_kind) == K_BEQ && $past(opnd_a) == $past(opnd_b)) |-> taken);

    // R6
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && link_we) |-> (link_val == $past(cur_pc) + FOUR));

    // R7
    jabs_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_kind) == K_JABS) |->
        (taken && next_pc[1:0] == 2'b00 && next_pc[XLEN-1 -: 4] == ($past(cur_pc) + FOUR) >> (XLEN-4)));

    // R9
    jreg_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_kind) == K_JREG) |->
        (taken && !link_we && next_pc == $past(jreg_val)));

endmodule

bind bnpc_unit bnpc_unit_chk #(.XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_pc    (cur_pc),
    .br_kind   (br_kind),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .br_off    (br_off),
    .jmp_field (jmp_field),
    .jreg_val  (jreg_val),
    .next_pc   (next_pc),
    .taken     (taken),
    .link_we   (link_we),
    .link_val  (link_val)
);

// File: tb/test_bnpc_unit.sv
module test_bnpc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [3:0]  br_kind = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] jreg_val = '0;
    logic [31:0] next_pc;
    logic        taken;
    logic        link_we;
    logic [31:0] link_val;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bnpc_unit i_bnpc_unit (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .br_kind(br_kind),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .br_off(br_off),
        .jmp_field(jmp_field), .jreg_val(jreg_val),
        .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_val(link_val)
    );

    logic [31:0] pats [6] = '{32'h0, 32'h1, 32'hffffffff, 32'h80000000, 32'h7fffffff, 32'h5};
    logic [15:0] offs [5] = '{16'h0, 16'h1, 16'h7fff, 16'h8000, 16'hffff};
    logic [31:0] pcs  [4] = '{32'h0, 32'h0ffffffc, 32'hfffffffc, 32'h12345678};

    function automatic string tag_of(input logic [3:0] k);
        case (k)
            4'd1, 4'd2:             return "R3";
            4'd3, 4'd4, 4'd5, 4'd6: return "R4";
            4'd7, 4'd8:             return "R6";
            4'd9:                   return "R7";
            4'd10:                  return "R8";
            4'd11:                  return "R9";
            default:                return "R2";
        endcase
    endfunction

    // Expected results computed from the requirement text
    logic [31:0] e_pc, e_lv;
    logic        e_tk, e_we;
    task automatic model();
        logic [31:0] s = cur_pc + 32'd4;
        longint      off = longint'($signed(br_off)) * 4;
        logic [31:0] rel = s + 32'(off);
        logic [31:0] abs = {s[31:28], jmp_field, 2'b00};
        bit cnd = 0;
        bit br = 0;
        int sa = $signed(opnd_a);
        e_we = 0; e_tk = 0; e_pc = s; e_lv = s;
        case (br_kind)
            4'd1: begin br = 1; cnd = (opnd_a == opnd_b); end
            4'd2: begin br = 1; cnd = (opnd_a != opnd_b); end
            4'd3: begin br = 1; cnd = (sa <= 0); end
            4'd4: begin br = 1; cnd = (sa > 0); end
            4'd5: begin br = 1; cnd = (sa < 0); end
            4'd6: begin br = 1; cnd = (sa >= 0); end
            4'd7: begin br = 1; cnd = (sa < 0);  e_we = 1; end
            4'd8: begin br = 1; cnd = (sa >= 0); e_we = 1; end
            4'd9:  begin e_tk = 1; e_pc = abs; end
            4'd10: begin e_tk = 1; e_pc = abs; e_we = 1; end
            4'd11: begin e_tk = 1; e_pc = jreg_val; end
            default: ;
        endcase
        if (br && cnd) begin e_tk = 1; e_pc = rel; end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (next_pc !== e_pc || taken !== e_tk || link_we !== e_we || (e_we && link_val !== e_lv)) begin
            errors++;
            $display("FAIL %s kind=%0d pc=%h a=%h b=%h off=%h: got pc=%h tk=%b we=%b lv=%h exp pc=%h tk=%b we=%b lv=%h",
                     tag, br_kind, cur_pc, opnd_a, opnd_b, br_off, next_pc, taken, link_we, link_val,
                     e_pc, e_tk, e_we, e_lv);
        end
    endtask

    // Drive at negedge, sample at the following negedge (one register)
    task automatic apply(input string tag);
        @(negedge clk);
        model();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        // R1: reset clears outputs
        cur_pc = 32'h00400000; br_kind = 4'd11; jreg_val = 32'hdeadbeec;
        repeat (3) @(negedge clk);
        checks++;
        if (next_pc !== 0 || taken !== 0 || link_we !== 0 || link_val !== 0) begin
            errors++;
            $display("FAIL R1 got pc=%h tk=%b we=%b lv=%h exp all zero", next_pc, taken, link_we, link_val);
        end
        rst_n = 1'b1;

        // Sweep every kind against boundary operand pairs
        for (int k = 0; k < 16; k++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++) begin
                    @(negedge clk);
                    br_kind = 4'(k); opnd_a = pats[i]; opnd_b = pats[j];
                    cur_pc = pcs[(i + k) % 4]; br_off = offs[(j + k) % 5];
                    jmp_field = 26'h2aaaaab ^ 26'(i * 977 + j);
                    jreg_val = pats[j] ^ 32'h5a5a0000;
                    model();
                    @(negedge clk);
                    compare(tag_of(4'(k)));
                end

        // R5: displacement extremes against PC values, BEQ always equal
        for (int p = 0; p < 4; p++)
            for (int o = 0; o < 5; o++) begin
                @(negedge clk);
                br_kind = 4'd1; opnd_a = 32'h77; opnd_b = 32'h77;
                cur_pc = pcs[p]; br_off = offs[o];
                model();
                @(negedge clk);
                compare("R5");
            end

        // R10: output holds until the clock edge
        @(negedge clk);
        br_kind = 4'd0; cur_pc = 32'h100;
        @(negedge clk);
        br_kind = 4'd11; jreg_val = 32'hcafe0000;
        #1;
        checks++;
        if (next_pc !== 32'h104) begin
            errors++;
            $display("FAIL R10 got pc=%h exp pc=%h before edge", next_pc, 32'h104);
        end
        model();
        @(negedge clk);
        compare("R10");

        // R1: reset mid-run clears outputs again
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (next_pc !== 0 || taken !== 0 || link_we !== 0 || link_val !== 0) begin
            errors++;
            $display("FAIL R1 mid-run got pc=%h tk=%b we=%b lv=%h exp all zero", next_pc, taken, link_we, link_val);
        end
        rst_n = 1'b1;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired got hung exp completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule